// File: doc/BRIEF.md
# Serial Command Frame Decoder with Packet Check

This block is the slave-side serial front end of a multi-channel output controller. A host shifts command frames in MSB first on a data line, clocked by a serial clock, while holding an active-low frame select. All three lines are brought into the block's own clock domain through a synchronizer chain. Edges of the serial clock and of frame select are then detected there, so the serial clock must run at a few times less than the system clock.

When frame select rises, the block looks at how many bits arrived. A 24-bit frame is a bare command. A 32-bit frame is the same command followed by an 8-bit CRC, which must match before anything happens. The command is acted on only if its device-address field equals the two strap inputs. It carries a direction flag, a 3-bit register selector, a 2-bit channel and 16 data bits. A write becomes a one-cycle strobe with selector, channel and data. A read becomes a one-cycle read strobe. The register file answers it with a 16-bit value, which the block returns on the data-out line during the next frame.

A CRC mismatch on a frame for this device blocks the frame and pulls the active-low fault output. Any frame whose length is neither 24 nor 32 bits is dropped silently.

Top module: `spi_cmd_frontend`

## Requirements
- R1: A 24-bit frame whose bits 22:21 equal `devStrap` and whose bit 23 is 0 gives exactly one `wrStrobe` cycle. In that cycle `wrSel` = bits 20:18, `wrChan` = bits 17:16, `wrData` = bits 15:0 and `wrAll` = 0, unless R3 applies.
- R2: A frame whose bits 22:21 differ from `devStrap` produces no strobe, leaves `faultN` unchanged and arms no readback, whatever its length or CRC.
- R3: Selector code 3'b011 is a broadcast gain write. It gives `wrSel` = 3'b010 and `wrAll` = 1. Every other selector passes through unchanged with `wrAll` = 0.
- R4: In a 32-bit frame, bits 31:8 are the command and bits 7:0 are a CRC. The CRC uses polynomial x^8+x^2+x+1 (0x07), starts at 0x00 and is taken over the 24 command bits MSB first. When it matches, the command is acted on as in R1, R3 and R7.
- R5: A 32-bit frame for this device with a CRC mismatch produces no strobe and drives `faultN` low. `faultN` stays low through 24-bit frames and rises again only on a 32-bit frame for this device with a matching CRC. It is 1 after reset.
- R6: A frame of any length other than 24 or 32 bits produces no strobe and leaves `faultN` and the readback state unchanged.
- R7: A frame with bit 23 = 1 gives exactly one `rdStrobe` cycle, with `rdSel` = bits 20:18 and `rdChan` = bits 17:16, and no `wrStrobe`. Its data bits have no effect.
- R8: After an accepted read, the next frame shifts out 24 bits MSB first: {1'b0, `devStrap`, `rdSel`, `rdChan`, `rdData` sampled in the `rdStrobe` cycle}. The first bit is valid once select falls, and each later bit follows a serial-clock falling edge. A frame with no read armed before it shifts out zeros.
- R9: `misoEn` is low whenever `csN` is high and high whenever `csN` is low.
- R10: `wrStrobe` and `rdStrobe` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low, data sampled on its rising edge |
| mosi | input | 1 | Serial command data in |
| csN | input | 1 | Active-low frame select |
| devStrap | input | 2 | Strapped device address |
| rdData | input | 16 | Register file reply, sampled in the `rdStrobe` cycle |
| wrStrobe | output | 1 | One-cycle write request |
| wrSel | output | 3 | Register selector of the write |
| wrChan | output | 2 | Channel of the write |
| wrAll | output | 1 | Write applies to every channel |
| wrData | output | 16 | Write data |
| rdStrobe | output | 1 | One-cycle read request |
| rdSel | output | 3 | Register selector of the read |
| rdChan | output | 2 | Channel of the read |
| misoData | output | 1 | Serial readback data |
| misoEn | output | 1 | Output enable for the data-out pad; low means high-impedance |
| faultN | output | 1 | Active-low packet error indication |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, polynomial 0x07 and a zero CRC seed. It drives a serial clock with a half period of six system clocks, which leaves enough margin for the synchronizer delay before each edge takes effect. With these values the bench reaches frame lengths just above and below both legal lengths, matching and corrupted CRC bytes, and the full set-and-clear cycle of the fault output. It also covers readback chained across consecutive frames, read and write requests sent to a foreign address, and the broadcast selector.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int CMD_W   = 24;
  localparam int CRC_W   = 8;
  localparam int LONG_W  = CMD_W + CRC_W;
  localparam int DATA_W  = 16;
  localparam int SEL_W   = 3;
  localparam int CHAN_W  = 2;
  localparam int DEV_W   = 2;
  localparam int RESP_W  = 1 + DEV_W + SEL_W + CHAN_W + DATA_W;

  // Command field positions (decoded by the host side as well)
  localparam int RW_BIT   = 23;
  localparam int DEV_LSB  = 21;
  localparam int SEL_LSB  = 18;
  localparam int CHAN_LSB = 16;

  localparam logic [SEL_W-1:0] SEL_GAIN     = 3'b010;
  localparam logic [SEL_W-1:0] SEL_GAIN_ALL = 3'b011;

  typedef struct packed {
    logic frameStart;
    logic bitIn;
    logic bitOut;
    logic captureResp;
  } dpStrobe_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] acc,
                                               input logic din,
                                               input logic [CRC_W-1:0] poly);
    logic fb;
    fb = acc[CRC_W-1] ^ din;
    crcStep = {acc[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RST_VAL}};
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/spi_cmd_dpath.sv
module spi_cmd_dpath
  import spi_cmd_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
  parameter logic [CRC_W-1:0] CRC_INIT = 8'h00,
  parameter int               CNT_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic              mosiS,
  input  logic [DEV_W-1:0]  devStrap,
  input  logic [SEL_W-1:0]  rdSel,
  input  logic [CHAN_W-1:0] rdChan,
  input  logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  bitCount,
  output logic [CMD_W-1:0]  cmdWord,
  output logic              crcOk,
  output logic              misoData
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_LONG = CNT_W'(LONG_W);

  logic [LONG_W-1:0] shiftReg;
  logic [CRC_W-1:0]  crcAcc;
  logic [RESP_W-1:0] respWord;
  logic [RESP_W-1:0] respShift;
  logic              respArmed;

  // Inbound shifting, length counting and running CRC
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCount <= '0;
      crcAcc   <= CRC_INIT;
    end else if (st.frameStart) begin
      bitCount <= '0;
      crcAcc   <= CRC_INIT;
    end else if (st.bitIn) begin
      shiftReg <= {shiftReg[LONG_W-2:0], mosiS};
      if (bitCount != CNT_MAX) bitCount <= bitCount + 1'b1;
      if (bitCount < CNT_CMD)  crcAcc <= crcStep(crcAcc, mosiS, CRC_POLY);
    end
  end

  assign cmdWord = (bitCount == CNT_LONG) ? shiftReg[LONG_W-1:CRC_W] : shiftReg[CMD_W-1:0];
  assign crcOk   = (shiftReg[CRC_W-1:0] == crcAcc);

  // Readback capture and outbound shifting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respWord  <= '0;
      respShift <= '0;
      respArmed <= 1'b0;
    end else begin
      if (st.frameStart) begin
        respShift <= respArmed ? respWord : '0;
        respArmed <= 1'b0;
      end else if (st.bitOut) begin
        respShift <= {respShift[RESP_W-2:0], 1'b0};
      end
      if (st.captureResp) begin
        respWord  <= {1'b0, devStrap, rdSel, rdChan, rdData};
        respArmed <= 1'b1;
      end
    end
  end

  assign misoData = respShift[RESP_W-1];

  // R4: the CRC accumulator stops once the command part has been shifted in
  a_r4_crc_frozen_after_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (st.bitIn && !st.frameStart && bitCount >= CNT_CMD) |=> $stable(crcAcc));

  // R6: the length counter moves only on a sampled bit or a new frame
  a_r6_count_only_on_bits: assert property (@(posedge clk) disable iff (!rstN)
    (!st.bitIn && !st.frameStart) |=> $stable(bitCount));

  // R8: a started frame with nothing armed begins with a zero bit
  a_r8_idle_response_zero: assert property (@(posedge clk) disable iff (!rstN)
    (st.frameStart && !respArmed && !st.captureResp) |=> !misoData);

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkS,
  input  logic              csS,
  input  logic [DEV_W-1:0]  devStrap,
  input  logic [CNT_W-1:0]  bitCount,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              crcOk,
  output dpStrobe_t         st,
  output logic              wrStrobe,
  output logic [SEL_W-1:0]  wrSel,
  output logic [CHAN_W-1:0] wrChan,
  output logic              wrAll,
  output logic [DATA_W-1:0] wrData,
  output logic              rdStrobe,
  output logic [SEL_W-1:0]  rdSel,
  output logic [CHAN_W-1:0] rdChan,
  output logic              faultN
);

  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_LONG = CNT_W'(LONG_W);

  logic sclkQ, csQ;
  logic sclkRise, sclkFall, csFall, csRise;
  logic lenShort, lenLong, addrHit;
  logic accept, crcBad, crcGood;
  logic crcErr;
  logic [SEL_W-1:0]  cmdSel;
  logic [CHAN_W-1:0] cmdChan;
  logic              cmdRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      csQ   <= 1'b1;
    end else begin
      sclkQ <= sclkS;
      csQ   <= csS;
    end
  end

  assign sclkRise = sclkS & ~sclkQ;
  assign sclkFall = ~sclkS & sclkQ;
  assign csFall   = ~csS & csQ;
  assign csRise   = csS & ~csQ;

  always_comb begin
    st             = '0;
    st.frameStart  = csFall;
    st.bitIn       = sclkRise & ~csS;
    st.bitOut      = sclkFall & ~csS;
    st.captureResp = rdStrobe;
  end

  // Frame-end decode
  assign cmdRead  = cmdWord[RW_BIT];
  assign cmdSel   = cmdWord[SEL_LSB +: SEL_W];
  assign cmdChan  = cmdWord[CHAN_LSB +: CHAN_W];
  assign lenShort = (bitCount == CNT_CMD);
  assign lenLong  = (bitCount == CNT_LONG);
  assign addrHit  = (cmdWord[DEV_LSB +: DEV_W] == devStrap);
  assign accept   = csRise & addrHit & (lenShort | (lenLong & crcOk));
  assign crcBad   = csRise & addrHit & lenLong & ~crcOk;
  assign crcGood  = csRise & addrHit & lenLong & crcOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      rdStrobe <= 1'b0;
      wrSel    <= '0;
      wrChan   <= '0;
      wrAll    <= 1'b0;
      wrData   <= '0;
      rdSel    <= '0;
      rdChan   <= '0;
    end else begin
      wrStrobe <= accept & ~cmdRead;
      rdStrobe <= accept & cmdRead;
      if (accept && !cmdRead) begin
        wrSel  <= (cmdSel == SEL_GAIN_ALL) ? SEL_GAIN : cmdSel;
        wrAll  <= (cmdSel == SEL_GAIN_ALL);
        wrChan <= cmdChan;
        wrData <= cmdWord[DATA_W-1:0];
      end
      if (accept && cmdRead) begin
        rdSel  <= cmdSel;
        rdChan <= cmdChan;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        crcErr <= 1'b0;
    else if (crcBad)  crcErr <= 1'b1;
    else if (crcGood) crcErr <= 1'b0;
  end

  assign faultN = ~crcErr;

  // R10: read and write requests are exclusive
  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStrobe && rdStrobe));

  // R10: a write request lasts a single cycle
  a_r10_write_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R7: a read request lasts a single cycle
  a_r7_read_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> !rdStrobe);

  // R1: requests only follow the end of a frame
  a_r1_strobe_after_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe || rdStrobe) |-> $past(csRise));

  // R5: the fault output only falls after a long frame ends
  a_r5_fault_on_long_frame: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultN) |-> $past(csRise && lenLong));

  // R6: frames of illegal length change nothing
  a_r6_bad_length_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && !lenShort && !lenLong) |=> (!wrStrobe && !rdStrobe && $stable(faultN)));

  // R2: a foreign address changes nothing
  a_r2_foreign_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (csRise && !addrHit) |=> (!wrStrobe && !rdStrobe && $stable(faultN)));

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spi_cmd_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [CRC_W-1:0] CRC_POLY    = 8'h07,
  parameter logic [CRC_W-1:0] CRC_INIT    = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              csN,
  input  logic [DEV_W-1:0]  devStrap,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrStrobe,
  output logic [SEL_W-1:0]  wrSel,
  output logic [CHAN_W-1:0] wrChan,
  output logic              wrAll,
  output logic [DATA_W-1:0] wrData,
  output logic              rdStrobe,
  output logic [SEL_W-1:0]  rdSel,
  output logic [CHAN_W-1:0] rdChan,
  output logic              misoData,
  output logic              misoEn,
  output logic              faultN
);

  localparam int CNT_W = $clog2(LONG_W + 2);

  logic [2:0]         syncOut;
  logic               csS, sclkS, mosiS;
  dpStrobe_t          st;
  logic [CNT_W-1:0]   bitCount;
  logic [CMD_W-1:0]   cmdWord;
  logic               crcOk;

  spi_cmd_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din ({csN, sclk, mosi}),
    .dout(syncOut)
  );

  assign {csS, sclkS, mosiS} = syncOut;

  spi_cmd_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .sclkS   (sclkS),
    .csS     (csS),
    .devStrap(devStrap),
    .bitCount(bitCount),
    .cmdWord (cmdWord),
    .crcOk   (crcOk),
    .st      (st),
    .wrStrobe(wrStrobe),
    .wrSel   (wrSel),
    .wrChan  (wrChan),
    .wrAll   (wrAll),
    .wrData  (wrData),
    .rdStrobe(rdStrobe),
    .rdSel   (rdSel),
    .rdChan  (rdChan),
    .faultN  (faultN)
  );

  spi_cmd_dpath #(
    .CRC_POLY(CRC_POLY),
    .CRC_INIT(CRC_INIT),
    .CNT_W   (CNT_W)
  ) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .mosiS   (mosiS),
    .devStrap(devStrap),
    .rdSel   (rdSel),
    .rdChan  (rdChan),
    .rdData  (rdData),
    .bitCount(bitCount),
    .cmdWord (cmdWord),
    .crcOk   (crcOk),
    .misoData(misoData)
  );

  // The pad is only driven while a frame is selected
  assign misoEn = ~csN;

endmodule

// File: tb/spi_cmd_frontend_tb_top.sv
module spi_cmd_frontend_tb_top;

  localparam int HALF     = 6;
  localparam int WATCHDOG = 150000;
  localparam logic [1:0] STRAP = 2'b01;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, csN = 1'b1;
  logic [1:0]  devStrap = STRAP;
  logic [15:0] rdData;
  logic        wrStrobe, wrAll, rdStrobe, misoData, misoEn, faultN;
  logic [2:0]  wrSel, rdSel;
  logic [1:0]  wrChan, rdChan;
  logic [15:0] wrData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Expected behaviour state
  logic [21:0] wrQ[$];
  logic [4:0]  rdQ[$];
  logic        faultExp = 1'b1;
  logic        armExp = 1'b0;
  logic [23:0] respExp = '0;

  always #10 clk = ~clk;

  spi_cmd_frontend dut_i (
    .clk(clk), .rstN(rstN), .sclk(sclk), .mosi(mosi), .csN(csN),
    .devStrap(devStrap), .rdData(rdData),
    .wrStrobe(wrStrobe), .wrSel(wrSel), .wrChan(wrChan), .wrAll(wrAll), .wrData(wrData),
    .rdStrobe(rdStrobe), .rdSel(rdSel), .rdChan(rdChan),
    .misoData(misoData), .misoEn(misoEn), .faultN(faultN)
  );

  function automatic logic [15:0] regReply(input logic [2:0] s, input logic [1:0] c);
    return {4'hC, s, c, 7'h2B};
  endfunction

  assign rdData = regReply(rdSel, rdChan);

  function automatic logic [7:0] refCrc(input logic [23:0] c);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      if (r[7] ^ c[i]) r = (r << 1) ^ 8'h07;
      else             r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [23:0] mk(input logic rw, input logic [1:0] a,
                                     input logic [2:0] s, input logic [1:0] c,
                                     input logic [15:0] d);
    return {rw, a, s, c, d};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Model of the frame end
  task automatic modelEnd(input logic [63:0] w, input int n);
    logic [23:0] c;
    if (n != 24 && n != 32) return;
    c = (n == 32) ? w[31:8] : w[23:0];
    if (c[22:21] != STRAP) return;
    if (n == 32) begin
      if (refCrc(c) != w[7:0]) begin
        faultExp = 1'b0;
        return;
      end
      faultExp = 1'b1;
    end
    if (c[23]) begin
      rdQ.push_back({c[20:18], c[17:16]});
      armExp  = 1'b1;
      respExp = {1'b0, STRAP, c[20:18], c[17:16], regReply(c[20:18], c[17:16])};
    end else begin
      wrQ.push_back({(c[20:18] == 3'b011) ? 3'b010 : c[20:18], c[17:16],
                     c[20:18] == 3'b011, c[15:0]});
    end
  endtask

  task automatic doFrame(input logic [63:0] w, input int n, input string tag);
    logic [31:0] got;
    logic [23:0] expResp;
    got = '0;
    expResp = armExp ? respExp : 24'h0;
    armExp = 1'b0;
    @(negedge clk);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = w[i];
      repeat (HALF) @(negedge clk);
      got = {got[30:0], misoData};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    modelEnd(w, n);
    csN = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    #2;
    if (n >= 24 && n <= 32)
      chk(got[n-1 -: 24] == expResp, "R8 readback word", 64'(got[n-1 -: 24]), 64'(expResp));
    chk(wrQ.size() == 0, {tag, " pending writes"}, 64'(wrQ.size()), 0);
    chk(rdQ.size() == 0, {tag, " pending reads"}, 64'(rdQ.size()), 0);
    chk(faultN == faultExp, {tag, " faultN"}, 64'(faultN), 64'(faultExp));
    wrQ.delete();
    rdQ.delete();
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rstN && !done) begin
      chk(misoEn == !csN, "R9 misoEn", 64'(misoEn), 64'(!csN));
      chk(!(wrStrobe && rdStrobe), "R10 exclusive", 64'({wrStrobe, rdStrobe}), 0);
      if (wrStrobe) begin
        if (wrQ.size() == 0) chk(1'b0, "R1 unexpected write", 64'({wrSel, wrChan, wrAll, wrData}), 0);
        else begin
          logic [21:0] e;
          e = wrQ.pop_front();
          chk({wrSel, wrChan, wrAll, wrData} == e, "R1 write fields",
              64'({wrSel, wrChan, wrAll, wrData}), 64'(e));
        end
      end
      if (rdStrobe) begin
        if (rdQ.size() == 0) chk(1'b0, "R7 unexpected read", 64'({rdSel, rdChan}), 0);
        else begin
          logic [4:0] e;
          e = rdQ.pop_front();
          chk({rdSel, rdChan} == e, "R7 read fields", 64'({rdSel, rdChan}), 64'(e));
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog act=%0d exp=0", WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] c;
    repeat (4) @(negedge clk);
    #2;
    chk(faultN == 1'b1, "R5 reset faultN", 64'(faultN), 1);
    chk(wrStrobe == 1'b0 && rdStrobe == 1'b0, "R10 reset strobes", 64'({wrStrobe, rdStrobe}), 0);
    chk(misoEn == 1'b0, "R9 reset misoEn", 64'(misoEn), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 plain writes
    doFrame(64'(mk(0, STRAP, 3'b000, 2'd2, 16'h1234)), 24, "R1");
    doFrame(64'(mk(0, STRAP, 3'b010, 2'd3, 16'h00FF)), 24, "R1");
    // R2 foreign address
    doFrame(64'(mk(0, 2'b10, 3'b000, 2'd1, 16'hBEEF)), 24, "R2");
    doFrame(64'(mk(0, 2'b11, 3'b010, 2'd0, 16'h4444)), 24, "R2");
    // R3 broadcast gain
    doFrame(64'(mk(0, STRAP, 3'b011, 2'd1, 16'hA5A5)), 24, "R3");
    // R4 good CRC
    c = mk(0, STRAP, 3'b101, 2'd0, 16'h8001);
    doFrame(64'({c, refCrc(c)}), 32, "R4");
    // R5 bad CRC, then short write, then foreign bad CRC, then good CRC
    c = mk(0, STRAP, 3'b001, 2'd2, 16'h0F0F);
    doFrame(64'({c, refCrc(c) ^ 8'h01}), 32, "R5");
    doFrame(64'(mk(0, STRAP, 3'b000, 2'd0, 16'h5555)), 24, "R5");
    c = mk(0, 2'b00, 3'b001, 2'd2, 16'h0F0F);
    doFrame(64'({c, refCrc(c) ^ 8'h80}), 32, "R2");
    doFrame(64'(mk(0, STRAP, 3'b000, 2'd1, 16'h0001)), 31, "R6");
    c = mk(0, STRAP, 3'b110, 2'd3, 16'hFFFF);
    doFrame(64'({c, refCrc(c)}), 32, "R5");
    // R6 illegal lengths
    doFrame(64'(mk(0, STRAP, 3'b000, 2'd0, 16'h1111)), 23, "R6");
    doFrame(64'(mk(0, STRAP, 3'b000, 2'd0, 16'h2222)) << 1, 25, "R6");
    doFrame(64'hFF, 8, "R6");
    c = mk(0, STRAP, 3'b000, 2'd0, 16'h3333);
    doFrame({24'h0, c, refCrc(c), 8'h00}, 40, "R6");
    doFrame(64'({c, refCrc(c), 1'b0}), 33, "R6");
    // R7 / R8 readback
    doFrame(64'h00A80000, 24, "R7");
    doFrame(64'(mk(0, STRAP, 3'b001, 2'd1, 16'h7777)), 24, "R8");
    doFrame(64'(mk(0, STRAP, 3'b000, 2'd2, 16'h6666)), 24, "R8");
    c = mk(1, STRAP, 3'b100, 2'd3, 16'hFFFF);
    doFrame(64'({c, refCrc(c)}), 32, "R7");
    doFrame(64'(mk(0, 2'b10, 3'b000, 2'd0, 16'h0000)), 24, "R8");
    doFrame(64'(mk(1, 2'b11, 3'b010, 2'd1, 16'h0000)), 24, "R2");
    doFrame(64'(mk(0, 2'b11, 3'b000, 2'd0, 16'h0000)), 24, "R8");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule